// File: doc/BRIEF.md
# Per-Module Clock Gating Idle Controller

This block handles power management for one slave module. Software writes a two-bit module-mode field. From that field, a clock-domain sleep request, the module's idle acknowledge and the module's wake-up line, a four-state machine decides when to raise the idle request toward the module. The machine also reports a two-bit idle status. Registered enables for the interface clock, the functional clock, a standby-protocol clock and a set of optional clocks are sent to external clock gate cells.

With mode 2 (enabled), the functional clock keeps running. The idle request follows the clock-domain sleep request, and an acknowledged idle gates only the interface clock. Any other mode value is handled as disabled: the request is raised at once with no condition, and an acknowledged idle gates both clocks. The stored field still reads back whatever value was written.

The states are RUN, ENTER, IDLE and EXIT:

| State | Idle status | Idle request |
|---|---|---|
| RUN | 0 | 0 |
| ENTER | 1 | 1 |
| IDLE | 2 in enabled mode, 3 otherwise | 1 |
| EXIT | 1 | 0 |

The transitions are:

- RUN→ENTER when idle is wanted.
- ENTER→EXIT when the wish is withdrawn.
- ENTER→IDLE on acknowledge.
- IDLE→EXIT when idle is no longer wanted.
- EXIT→RUN once the acknowledge is low.

Idle is wanted when the mode is disabled or the sleep request is high, and the slave wake-up is low.

Top module: `modclk_idle_ctrl`

## Requirements
- R1: Reset behaviour.
  - While reset is held, the idle status is 0, the idle request is 0 and every clock enable is 0.
  - The mode field reads 2.
- R2: Mode readback.
  - A write strobe stores the write data into the mode field on that clock edge.
  - `mode_rdata` shows the stored value after that edge, including the reserved values 1 and 3.
- R3: Disabled and reserved modes.
  - With a stored mode of 0, 1 or 3, the idle request rises on the edge after the mode is stored, whatever the sleep request is.
  - After the acknowledge is sampled, the status is 3 and both the interface and functional enables are 0.
- R4: Enabled mode.
  - With mode 2, the idle request follows the sleep request.
  - After the acknowledge is sampled, the status is 2, the functional enable stays 1 and the interface enable is 0.
- R5: While the request is high and no acknowledge has been sampled, the status reads 1.
  - Status 2 or 3 appears only on an edge at which the acknowledge was high.
- R6: Exit from idle or from a pending request.
  - When idle is no longer wanted, the request drops on the next edge and the status reads 1.
  - The status stays 1 until an edge samples the acknowledge low, and then reads 0.
- R7: Slave wake-up.
  - A slave wake-up sampled high forces the idle request low on that edge.
  - It sets the interface enable (if the domain is ready) and takes status 2 or 3 to status 1.
- R8: Interface and functional enables.
  - The interface enable equals domain-ready AND (status is 0 OR status is 1 OR wake-up).
  - The functional enable equals domain-ready AND status is not 3.
  - Both use the inputs sampled at the same edge as the new status.
- R9: The standby clock enable equals domain-ready AND (NOT master standby OR master wake-up), registered one edge after sampling.
- R10: Each optional clock enable equals its software enable bit, registered one edge later, independent of domain-ready and of the handshakes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_wr | input | 1 | Write strobe for the mode field |
| mode_wdata | input | 2 | Mode value to store |
| mode_rdata | output | 2 | Stored mode value |
| dom_ready | input | 1 | Clock domain ready |
| dom_sleep_req | input | 1 | Clock domain requests a sleep transition |
| idle_ack | input | 1 | Idle acknowledge from the module |
| slv_wakeup | input | 1 | Slave wake-up from the module |
| mst_standby | input | 1 | Master standby from the module |
| mst_wakeup | input | 1 | Master wake-up from the module |
| opt_sw_en | input | OPT_N | Software enables for optional clocks |
| idle_req | output | 1 | Idle request to the module |
| idle_status | output | 2 | 0 functional, 1 transition, 2 interface idle, 3 full idle |
| iclk_en | output | 1 | Interface clock enable |
| fclk_en | output | 1 | Functional clock enable |
| stby_clk_en | output | 1 | Standby-protocol clock enable |
| opt_clk_en | output | OPT_N | Optional clock enables |

## Verification
The hardest situation to reach from the ports is a mode change while the module sits in IDLE. This includes writing a reserved value that must keep the block fully idle, then writing the enabled mode so that, with no sleep request, the block leaves idle. The stimulus first drives the block into full idle under disabled mode. It then writes 3, holds for a cycle, and writes 2 while the acknowledge is still high. This checks that the status stays 3 until the new mode is in effect, and then reads 1 until the acknowledge is released. The same idle entry is also reused to assert the slave wake-up and to drop the domain-ready input while the block is idle.

// File: rtl/modclk_pkg.sv
package modclk_pkg;

    localparam int MODE_W = 2;

    // Mode value that keeps the functional clock running
    localparam logic [MODE_W-1:0] MODE_ENABLED = 2'd2;

    typedef enum logic [1:0] {
        ST_RUN,
        ST_ENTER,
        ST_IDLE,
        ST_EXIT
    } pm_state_e;

    typedef enum logic [1:0] {
        STAT_FUNC  = 2'd0,
        STAT_TRANS = 2'd1,
        STAT_IIDLE = 2'd2,
        STAT_FIDLE = 2'd3
    } pm_status_e;

endpackage

// File: rtl/modclk_mode_reg.sv
module modclk_mode_reg
    import modclk_pkg::*;
#(
    parameter logic [MODE_W-1:0] RST_MODE = MODE_ENABLED
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [MODE_W-1:0] wdata,
    output logic [MODE_W-1:0] mode_q,
    output logic              gate_all
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= RST_MODE;
        end else if (wr) begin
            mode_q <= wdata;
        end
    end

    // Every value other than the enabled code behaves as disabled
    assign gate_all = (mode_q != MODE_ENABLED);

endmodule

// File: rtl/modclk_idle_fsm.sv
module modclk_idle_fsm
    import modclk_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      gate_all,
    input  logic      sleep_req,
    input  logic      wakeup,
    input  logic      ack,
    output pm_state_e state_d
);

    pm_state_e state_q;
    logic      want_idle;

    assign want_idle = (gate_all | sleep_req) & ~wakeup;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN: begin
                if (want_idle) state_d = ST_ENTER;
            end
            ST_ENTER: begin
                if (!want_idle)  state_d = ST_EXIT;
                else if (ack)    state_d = ST_IDLE;
            end
            ST_IDLE: begin
                if (!want_idle) state_d = ST_EXIT;
            end
            ST_EXIT: begin
                if (!ack) state_d = ST_RUN;
            end
            default: state_d = ST_RUN;
        endcase
    end

endmodule

// File: rtl/modclk_en_gen.sv
module modclk_en_gen
    import modclk_pkg::*;
#(
    parameter int OPT_N = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  pm_state_e        state_d,
    input  logic             gate_all,
    input  logic             dom_ready,
    input  logic             wakeup,
    input  logic             mst_standby,
    input  logic             mst_wakeup,
    input  logic [OPT_N-1:0] opt_sw_en,
    output logic             idle_req,
    output logic [1:0]       idle_status,
    output logic             iclk_en,
    output logic             fclk_en,
    output logic             stby_clk_en,
    output logic [OPT_N-1:0] opt_clk_en
);

    pm_status_e stat_d;
    logic       req_d;

    always_comb begin
        stat_d = STAT_FUNC;
        req_d  = 1'b0;
        unique case (state_d)
            ST_RUN: begin
                stat_d = STAT_FUNC;
                req_d  = 1'b0;
            end
            ST_ENTER: begin
                stat_d = STAT_TRANS;
                req_d  = 1'b1;
            end
            ST_IDLE: begin
                stat_d = gate_all ? STAT_FIDLE : STAT_IIDLE;
                req_d  = 1'b1;
            end
            ST_EXIT: begin
                stat_d = STAT_TRANS;
                req_d  = 1'b0;
            end
            default: begin
                stat_d = STAT_FUNC;
                req_d  = 1'b0;
            end
        endcase
    end

    // Output register: all enables move only on controller clock edges
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idle_req    <= 1'b0;
            idle_status <= STAT_FUNC;
            iclk_en     <= 1'b0;
            fclk_en     <= 1'b0;
            stby_clk_en <= 1'b0;
        end else begin
            idle_req    <= req_d;
            idle_status <= stat_d;
            iclk_en     <= dom_ready & ((stat_d == STAT_FUNC) | (stat_d == STAT_TRANS) | wakeup);
            fclk_en     <= dom_ready & (stat_d != STAT_FIDLE);
            stby_clk_en <= dom_ready & (~mst_standby | mst_wakeup);
        end
    end

    for (genvar g = 0; g < OPT_N; g++) begin : g_opt
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                opt_clk_en[g] <= 1'b0;
            end else begin
                opt_clk_en[g] <= opt_sw_en[g];
            end
        end
    end

endmodule

// File: rtl/modclk_idle_ctrl.sv
module modclk_idle_ctrl
    import modclk_pkg::*;
#(
    parameter int OPT_N = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_wr,
    input  logic [1:0]       mode_wdata,
    output logic [1:0]       mode_rdata,
    input  logic             dom_ready,
    input  logic             dom_sleep_req,
    input  logic             idle_ack,
    input  logic             slv_wakeup,
    input  logic             mst_standby,
    input  logic             mst_wakeup,
    input  logic [OPT_N-1:0] opt_sw_en,
    output logic             idle_req,
    output logic [1:0]       idle_status,
    output logic             iclk_en,
    output logic             fclk_en,
    output logic             stby_clk_en,
    output logic [OPT_N-1:0] opt_clk_en
);

    logic      gate_all;
    pm_state_e state_d;

    modclk_mode_reg #(
        .RST_MODE (MODE_ENABLED)
    ) i_mode (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (mode_wr),
        .wdata    (mode_wdata),
        .mode_q   (mode_rdata),
        .gate_all (gate_all)
    );

    modclk_idle_fsm i_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .gate_all  (gate_all),
        .sleep_req (dom_sleep_req),
        .wakeup    (slv_wakeup),
        .ack       (idle_ack),
        .state_d   (state_d)
    );

    modclk_en_gen #(
        .OPT_N (OPT_N)
    ) i_en (
        .clk         (clk),
        .rst_n       (rst_n),
        .state_d     (state_d),
        .gate_all    (gate_all),
        .dom_ready   (dom_ready),
        .wakeup      (slv_wakeup),
        .mst_standby (mst_standby),
        .mst_wakeup  (mst_wakeup),
        .opt_sw_en   (opt_sw_en),
        .idle_req    (idle_req),
        .idle_status (idle_status),
        .iclk_en     (iclk_en),
        .fclk_en     (fclk_en),
        .stby_clk_en (stby_clk_en),
        .opt_clk_en  (opt_clk_en)
    );

endmodule

// File: rtl/modclk_idle_ctrl_chk.sv
module modclk_idle_ctrl_chk #(
    parameter int OPT_N = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             mode_wr,
    input logic [1:0]       mode_wdata,
    input logic [1:0]       mode_rdata,
    input logic             dom_ready,
    input logic             idle_ack,
    input logic             slv_wakeup,
    input logic             mst_standby,
    input logic             mst_wakeup,
    input logic [OPT_N-1:0] opt_sw_en,
    input logic             idle_req,
    input logic [1:0]       idle_status,
    input logic             iclk_en,
    input logic             fclk_en,
    input logic             stby_clk_en,
    input logic [OPT_N-1:0] opt_clk_en
);

    // R2
    mode_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_wr |=> (mode_rdata == $past(mode_wdata)));

    // R3
    full_idle_gates_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_status == 2'd3) |-> (!fclk_en && !iclk_en && idle_req));

    // R4
    iface_idle_keeps_fclk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_status == 2'd2) |-> (!iclk_en && (fclk_en == $past(dom_ready))));

    // R5
    idle_needs_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((idle_status[1]) && !$past(idle_status[1])) |-> $past(idle_ack));

    // R6
    run_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_status == 2'd0) |-> !idle_req);

    // R7
    wakeup_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (slv_wakeup && dom_ready) |=> (iclk_en && !idle_req && !idle_status[1]));

    // R8
    dom_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dom_ready |=> (!iclk_en && !fclk_en && !stby_clk_en));

    // R9
    standby_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mst_standby && !mst_wakeup) |=> !stby_clk_en);

    // R10
    opt_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (opt_clk_en == $past(opt_sw_en)));

endmodule

bind modclk_idle_ctrl modclk_idle_ctrl_chk #(.OPT_N(OPT_N)) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_wr     (mode_wr),
    .mode_wdata  (mode_wdata),
    .mode_rdata  (mode_rdata),
    .dom_ready   (dom_ready),
    .idle_ack    (idle_ack),
    .slv_wakeup  (slv_wakeup),
    .mst_standby (mst_standby),
    .mst_wakeup  (mst_wakeup),
    .opt_sw_en   (opt_sw_en),
    .idle_req    (idle_req),
    .idle_status (idle_status),
    .iclk_en     (iclk_en),
    .fclk_en     (fclk_en),
    .stby_clk_en (stby_clk_en),
    .opt_clk_en  (opt_clk_en)
);

// File: tb/test_modclk_idle_ctrl.sv
module test_modclk_idle_ctrl;

    localparam int OPT_N = 2;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             mode_wr = 1'b0;
    logic [1:0]       mode_wdata = 2'd0;
    logic [1:0]       mode_rdata;
    logic             dom_ready = 1'b1;
    logic             dom_sleep_req = 1'b0;
    logic             idle_ack = 1'b0;
    logic             slv_wakeup = 1'b0;
    logic             mst_standby = 1'b0;
    logic             mst_wakeup = 1'b0;
    logic [OPT_N-1:0] opt_sw_en = '0;
    logic             idle_req;
    logic [1:0]       idle_status;
    logic             iclk_en;
    logic             fclk_en;
    logic             stby_clk_en;
    logic [OPT_N-1:0] opt_clk_en;

    always #2 clk = ~clk;

    modclk_idle_ctrl #(.OPT_N(OPT_N)) i_modclk_idle_ctrl (.*);

    typedef struct {
        string            tag;
        logic [1:0]       st;
        logic             req;
        logic             ic;
        logic             fc;
        logic             sb;
        logic [OPT_N-1:0] op;
        logic [1:0]       md;
    } exp_t;

    exp_t q[$];
    int   n_chk = 0;
    int   n_fail = 0;
    bit   done = 1'b0;

    // shadow stimulus, copied to the pins at a falling edge
    logic             b_dom = 1'b1, b_sleep = 1'b0, b_ack = 1'b0, b_wake = 1'b0;
    logic             b_ms = 1'b0, b_mw = 1'b0, b_wr = 1'b0;
    logic [1:0]       b_wdata = 2'd0;
    logic [OPT_N-1:0] b_opt = '0;
    logic [1:0]       md = 2'd2;

    task automatic step(input string tag, input logic [1:0] st, input logic req);
        exp_t e;
        @(negedge clk);
        dom_ready     = b_dom;
        dom_sleep_req = b_sleep;
        idle_ack      = b_ack;
        slv_wakeup    = b_wake;
        mst_standby   = b_ms;
        mst_wakeup    = b_mw;
        opt_sw_en     = b_opt;
        mode_wr       = b_wr;
        mode_wdata    = b_wdata;
        if (b_wr) md = b_wdata;
        b_wr = 1'b0;
        e.tag = tag;
        e.st  = st;
        e.req = req;
        // R8 formulas
        e.ic  = b_dom & ((st == 2'd0) | (st == 2'd1) | b_wake);
        e.fc  = b_dom & (st != 2'd3);
        // R9 formula
        e.sb  = b_dom & (~b_ms | b_mw);
        // R10
        e.op  = b_opt;
        e.md  = md;
        q.push_back(e);
    endtask

    // monitor: compares after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                n_chk++;
                if (idle_status !== e.st || idle_req !== e.req || iclk_en !== e.ic ||
                    fclk_en !== e.fc || stby_clk_en !== e.sb || opt_clk_en !== e.op ||
                    mode_rdata !== e.md) begin
                    n_fail++;
                    $display("FAIL %s: act st=%0d req=%b ic=%b fc=%b sb=%b op=%b md=%0d exp st=%0d req=%b ic=%b fc=%b sb=%b op=%b md=%0d",
                             e.tag, idle_status, idle_req, iclk_en, fclk_en, stby_clk_en, opt_clk_en, mode_rdata,
                             e.st, e.req, e.ic, e.fc, e.sb, e.op, e.md);
                end
            end
        end
    end

    initial begin
        #20000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: act=hung exp=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        #7;
        // R1 reset state
        n_chk++;
        if (idle_status !== 2'd0 || idle_req !== 1'b0 || iclk_en !== 1'b0 || fclk_en !== 1'b0 ||
            stby_clk_en !== 1'b0 || opt_clk_en !== '0 || mode_rdata !== 2'd2) begin
            n_fail++;
            $display("FAIL R1: act st=%0d req=%b ic=%b fc=%b md=%0d exp st=0 req=0 ic=0 fc=0 md=2",
                     idle_status, idle_req, iclk_en, fclk_en, mode_rdata);
        end
        @(negedge clk);
        rst_n = 1'b1;

        step("R4 run no sleep", 2'd0, 1'b0);
        b_sleep = 1'b1;
        step("R5 request raised", 2'd1, 1'b1);
        step("R5 still no ack", 2'd1, 1'b1);
        b_ack = 1'b1;
        step("R4 interface idle", 2'd2, 1'b1);
        step("R4 hold idle", 2'd2, 1'b1);
        b_sleep = 1'b0;
        step("R6 exit ack high", 2'd1, 1'b0);
        b_ack = 1'b0;
        step("R6 exit done", 2'd0, 1'b0);
        b_sleep = 1'b1;
        step("R5 request again", 2'd1, 1'b1);
        b_sleep = 1'b0;
        step("R6 abort", 2'd1, 1'b0);
        step("R6 abort done", 2'd0, 1'b0);

        b_wr = 1'b1; b_wdata = 2'd0;
        step("R2 write disabled", 2'd0, 1'b0);
        step("R3 disabled request", 2'd1, 1'b1);
        b_ack = 1'b1;
        step("R3 full idle", 2'd3, 1'b1);
        b_wake = 1'b1;
        step("R7 wakeup", 2'd1, 1'b0);
        b_ack = 1'b0;
        step("R7 wakeup ack low", 2'd0, 1'b0);
        b_wake = 1'b0;
        step("R3 re-request", 2'd1, 1'b1);
        b_ack = 1'b1;
        step("R3 full idle again", 2'd3, 1'b1);
        b_dom = 1'b0;
        step("R8 domain off", 2'd3, 1'b1);
        b_dom = 1'b1;
        b_wr = 1'b1; b_wdata = 2'd3;
        step("R2 write reserved 3", 2'd3, 1'b1);
        step("R3 reserved 3 keeps idle", 2'd3, 1'b1);
        b_wr = 1'b1; b_wdata = 2'd2;
        step("R2 write enabled", 2'd3, 1'b1);
        step("R6 enabled leaves idle", 2'd1, 1'b0);
        b_ack = 1'b0;
        step("R6 back to run", 2'd0, 1'b0);

        b_ms = 1'b1;
        step("R9 standby gated", 2'd0, 1'b0);
        b_mw = 1'b1;
        step("R9 master wakeup", 2'd0, 1'b0);
        b_dom = 1'b0;
        step("R8 R9 domain off", 2'd0, 1'b0);
        b_dom = 1'b1; b_ms = 1'b0; b_mw = 1'b0;
        b_opt = 2'b01;
        step("R10 opt 01", 2'd0, 1'b0);
        b_opt = 2'b10; b_dom = 1'b0;
        step("R10 opt 10 domain off", 2'd0, 1'b0);
        b_dom = 1'b1; b_opt = 2'b00;

        b_wr = 1'b1; b_wdata = 2'd1;
        step("R2 write reserved 1", 2'd0, 1'b0);
        step("R3 reserved 1 request", 2'd1, 1'b1);
        b_ack = 1'b1;
        step("R3 reserved 1 full idle", 2'd3, 1'b1);
        b_sleep = 1'b1;
        step("R3 sleep input ignored", 2'd3, 1'b1);

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule